// File: doc/BRIEF.md
# Dual-Role SPI Byte Port with Mode Fault

This block is a byte-wide SPI port for a microcontroller. A small register port is used to program it, to read its flags and to move bytes. It runs either as the clock-generating master or as a clocked slave. In master mode, a write to the data register starts one eight-bit exchange. The serial clock comes from the system clock divided by 4, 8, 16 or 32. It runs for exactly sixteen edges and then stops at its idle level. In slave mode, the byte to send is loaded beforehand. The block then shifts whenever the remote master toggles the clock while the slave is selected.

The block also controls the pin directions. While disabled it drives none of its pins. As master it drives the serial clock and the master-out line. As slave it drives the master-in line only while selected. If a master that honours its select input sees that input pulled low, it gives up the master role at once: the hardware clears the role bit, any transfer in progress is aborted, and a mode-fault interrupt pulse is raised. If a slave's data register is written while a byte may be in flight, the write is refused and a collision flag is set.

The register port is plain. A write is taken on the clock edge where `reg_wr` is high, and it cannot be held off. Reads are combinational from `reg_addr`. The serial pins have no back-pressure. Bytes move only when the master clocks them.

Top module: `spi_dual_role`

Register map (`reg_addr`):

| Address | Contents |
|---|---|
| 0 | control: bit 7 enable, bit 6 select-ignore, bit 5 master role, bit 4 clock polarity (idle level), bit 3 clock phase, bit 2 interrupt enable, bits 1:0 divider code |
| 1 | status: bit 7 byte done, bit 6 write collision; writing 1 to a bit clears it, other bits read 0 |
| 2 | data: a write loads the byte to send (and starts a master transfer); a read returns the last received byte |

## Requirements
- R1: With control bit 7 at 0, `sclk_oe`, `mosi_oe` and `miso_oe` are all 0, and all registers read 0 after reset.
- R2: An enabled master has `sclk_oe`=1, `mosi_oe`=1 and `miso_oe`=0. Between bytes, `sclk_o` equals the polarity bit (control bit 4).
- R3: An enabled slave has `sclk_oe`=0 and `mosi_oe`=0. It drives `miso_oe`=1 only while selected, that is, when `ss_i` is low or select-ignore (bit 6) is 1.
- R4: A master transfer sends the written byte MSB first on `mosi_o` and receives a byte from `miso_i`, which the data register then returns. This holds in all four polarity/phase modes. With phase 0, data is sampled on the first edge of each bit (leading edge); with phase 1, on the second (trailing edge).
- R5: Each master clock half-period lasts 2, 4, 8 or 16 system clocks for divider codes 0, 1, 2 and 3, so the clock divides the system clock by 4, 8, 16 or 32.
- R6: A master transfer produces exactly 16 clock edges. After the last edge the clock rests at its idle level and status bit 7 is set.
- R7: A selected slave shifts out its loaded byte MSB first on `miso_o`, captures `mosi_i`, and after 16 clock edges sets status bit 7 and returns the byte from the data register.
- R8: A slave data write while `ss_i` is low (select-ignore 0) is discarded and sets status bit 6. The byte sent next is the one loaded before.
- R9: An enabled master with select-ignore 0 whose `ss_i` goes low clears control bit 5 and becomes a slave. When interrupts are enabled, it pulses `irq`.
- R10: With select-ignore 1, `ss_i` has no effect on the role: control bit 5 stays 1 and master transfers still complete.
- R11: Writing 1 to a status bit clears it. If the write lands in the same cycle as a new byte completion, the flag stays set.
- R12: `irq` is high while interrupt enable (bit 2) is 1 and the done flag is set, and it is low when the flag is cleared or the enable is 0.
- R13: A slave with phase 1 may keep `ss_i` low across consecutive bytes. Each group of 16 clock edges completes one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| reg_addr | input | 2 | register select |
| reg_wr | input | 1 | write strobe, taken on the clock edge |
| reg_wdata | input | 8 | write data |
| reg_rdata | output | 8 | read data for `reg_addr` |
| ss_i | input | 1 | slave-select pin level (active low) |
| sclk_i | input | 1 | serial clock in (slave) |
| sclk_o | output | 1 | serial clock out (master) |
| sclk_oe | output | 1 | serial clock output enable |
| mosi_i | input | 1 | master-out line in (slave) |
| mosi_o | output | 1 | master-out line out (master) |
| mosi_oe | output | 1 | master-out output enable |
| miso_i | input | 1 | master-in line in (master) |
| miso_o | output | 1 | master-in line out (slave) |
| miso_oe | output | 1 | master-in output enable |
| irq | output | 1 | interrupt request |

## Verification
The write-1-to-clear of the done flag and the completion of a new byte can fall on the same clock edge. The bench provokes this by timing a status clear to arrive exactly 32 clocks after a fastest-divider master start, which is the cycle in which the sixteenth clock edge sets the flag. A correct design must keep the flag set. An ordinary clear one cycle later must then remove it. Mode fault and collision are also exercised right next to live transfers, so that any leak of their effects into the shift path shows up in the compared bytes.

// File: rtl/spi_dr_pkg.sv
package spi_dr_pkg;
  localparam int DW     = 8;
  localparam int EDGES  = 2 * DW;
  localparam int ECW    = $clog2(EDGES);
  localparam int RATE_W = 2;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  typedef struct packed {
    logic              en;
    logic              ss_ign;
    logic              mstr;
    logic              cpol;
    logic              cpha;
    logic              ie;
    logic [RATE_W-1:0] rate;
  } ctrl_t;

  // idx counts edges already seen in the byte (0 = first edge coming)
  function automatic logic is_sample(input logic [ECW-1:0] idx, input logic cpha);
    return cpha ? idx[0] : ~idx[0];
  endfunction

  function automatic logic is_shift(input logic [ECW-1:0] idx, input logic cpha);
    if (cpha) return ~idx[0] && (idx != '0);
    return idx[0] && (idx != ECW'(EDGES - 1));
  endfunction
endpackage

// File: rtl/spi_dr_sync.sv
module spi_dr_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[g] <= RST_VAL;
        else        st[g] <= d;
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[g] <= RST_VAL;
        else        st[g] <= st[g-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/spi_dr_clkgen.sv
module spi_dr_clkgen #(
  parameter int RATE_W = 2,
  localparam int CNT_W = (1 << RATE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  // half period = 2^(rate+1) system clocks
  assign lim  = CNT_W'((32'd2 << rate) - 32'd1);
  assign tick = run && (cnt_q == lim);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     cnt_q <= '0;
    else if (!run)  cnt_q <= '0;
    else if (tick)  cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
endmodule

// File: rtl/spi_dr_engine.sv
module spi_dr_engine
  import spi_dr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          edge_i,
  input  logic          cpha,
  input  logic          sin,
  output logic          sout,
  output logic [DW-1:0] rx_full,
  output logic          byte_done,
  output logic          in_byte
);
  logic [ECW-1:0] idx_q;
  logic [DW-1:0]  tx_q, rx_q;
  logic           samp, shft;

  assign samp      = edge_i && is_sample(idx_q, cpha);
  assign shft      = edge_i && is_shift(idx_q, cpha);
  assign rx_full   = samp ? {rx_q[DW-2:0], sin} : rx_q;
  assign byte_done = edge_i && (idx_q == ECW'(EDGES - 1));
  assign in_byte   = (idx_q != '0);
  assign sout      = tx_q[DW-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      idx_q <= '0;
      tx_q  <= '0;
      rx_q  <= '0;
    end else begin
      if (clr || load)    idx_q <= '0;
      else if (byte_done) idx_q <= '0;
      else if (edge_i)    idx_q <= idx_q + 1'b1;

      if (load)      tx_q <= load_data;
      else if (shft) tx_q <= {tx_q[DW-2:0], 1'b0};

      if (clr || load) rx_q <= '0;
      else if (samp)   rx_q <= rx_full;
    end
endmodule

// File: rtl/spi_dual_role.sv
module spi_dual_role
  import spi_dr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       ss_i,
  input  logic       sclk_i,
  output logic       sclk_o,
  output logic       sclk_oe,
  input  logic       mosi_i,
  output logic       mosi_o,
  output logic       mosi_oe,
  input  logic       miso_i,
  output logic       miso_o,
  output logic       miso_oe,
  output logic       irq
);
  ctrl_t         ctrl_q;
  logic          done_q, col_q, busy_q, sclk_q, mf_q, sclk_s_d;
  logic [DW-1:0] rx_buf_q, rx_full;
  logic          ss_s, sclk_s, mosi_s;
  logic          wr_ctrl, wr_stat, wr_data;
  logic          is_master, is_slave, slv_sel, mode_fault;
  logic          m_tick, s_edge, eng_edge, eng_sin, eng_clr, eng_load;
  logic          m_load, s_load, col_evt, byte_done, in_byte, sout;

  spi_dr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ss_i, sclk_i, mosi_i}),
    .q({ss_s, sclk_s, mosi_s})
  );

  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_stat = reg_wr && (reg_addr == A_STAT);
  assign wr_data = reg_wr && (reg_addr == A_DATA);

  assign is_master  = ctrl_q.en && ctrl_q.mstr;
  assign is_slave   = ctrl_q.en && !ctrl_q.mstr;
  assign slv_sel    = is_slave && (ctrl_q.ss_ign || !ss_s);
  assign mode_fault = is_master && !ctrl_q.ss_ign && !ss_s;

  spi_dr_clkgen #(.RATE_W(RATE_W)) u_clkgen (
    .clk(clk), .rst_n(rst_n),
    .run(busy_q && is_master),
    .rate(ctrl_q.rate),
    .tick(m_tick)
  );

  assign s_edge   = slv_sel && (sclk_s != sclk_s_d);
  assign eng_edge = is_master ? m_tick : s_edge;
  assign eng_sin  = is_master ? miso_i : mosi_s;

  assign m_load   = wr_data && is_master && !busy_q && !mode_fault;
  assign col_evt  = wr_data && is_slave && (ctrl_q.ss_ign ? in_byte : !ss_s);
  assign s_load   = wr_data && is_slave && !col_evt;
  assign eng_load = m_load || s_load;
  assign eng_clr  = !ctrl_q.en || mode_fault || (is_slave && !slv_sel);

  spi_dr_engine u_engine (
    .clk(clk), .rst_n(rst_n),
    .clr(eng_clr),
    .load(eng_load),
    .load_data(reg_wdata),
    .edge_i(eng_edge),
    .cpha(ctrl_q.cpha),
    .sin(eng_sin),
    .sout(sout),
    .rx_full(rx_full),
    .byte_done(byte_done),
    .in_byte(in_byte)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl_q   <= '0;
      done_q   <= 1'b0;
      col_q    <= 1'b0;
      busy_q   <= 1'b0;
      sclk_q   <= 1'b0;
      mf_q     <= 1'b0;
      sclk_s_d <= 1'b0;
      rx_buf_q <= '0;
    end else begin
      if (wr_ctrl)    ctrl_q      <= ctrl_t'(reg_wdata);
      if (mode_fault) ctrl_q.mstr <= 1'b0;

      if (!is_master || mode_fault) busy_q <= 1'b0;
      else if (m_load)              busy_q <= 1'b1;
      else if (byte_done)           busy_q <= 1'b0;

      if (!busy_q || !is_master) sclk_q <= ctrl_q.cpol;
      else if (m_tick)           sclk_q <= !sclk_q;

      // completion beats a same-cycle clear
      done_q <= byte_done || (done_q && !(wr_stat && reg_wdata[7]));
      col_q  <= col_evt   || (col_q  && !(wr_stat && reg_wdata[6]));

      if (byte_done) rx_buf_q <= rx_full;
      mf_q     <= mode_fault;
      sclk_s_d <= sclk_s;
    end

  always_comb begin
    unique case (reg_addr)
      A_CTRL:  reg_rdata = ctrl_q;
      A_STAT:  reg_rdata = {done_q, col_q, 6'b0};
      A_DATA:  reg_rdata = rx_buf_q;
      default: reg_rdata = '0;
    endcase
  end

  assign sclk_oe = is_master;
  assign mosi_oe = is_master;
  assign miso_oe = slv_sel;
  assign sclk_o  = busy_q ? sclk_q : ctrl_q.cpol;
  assign mosi_o  = sout;
  assign miso_o  = sout;
  assign irq     = ctrl_q.ie && (done_q || mf_q);
endmodule

// File: rtl/spi_dr_chk.sv
module spi_dr_chk
  import spi_dr_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input ctrl_t ctrl,
  input logic  ss_s,
  input logic  sclk_o,
  input logic  sclk_oe,
  input logic  mosi_oe,
  input logic  miso_oe,
  input logic  irq,
  input logic  busy_q,
  input logic  done_q,
  input logic  col_q,
  input logic  byte_done,
  input logic  col_evt,
  input logic  wr_ctrl,
  input logic  wr_stat,
  input logic  w1c_done
);
  assert_pins_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.en |-> !(sclk_oe || mosi_oe || miso_oe));

  assert_miso_hiz_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.en && !ctrl.mstr && !ctrl.ss_ign && ss_s) |-> !miso_oe);

  assert_stop_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && byte_done && !wr_ctrl) |=> (!busy_q && sclk_o == ctrl.cpol));

  assert_collide_R8: assert property (@(posedge clk) disable iff (!rst_n)
    col_evt |=> col_q);

  assert_mode_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.en && ctrl.mstr && !ctrl.ss_ign && !ss_s && !wr_ctrl) |=> (!ctrl.mstr && !busy_q));

  assert_keep_master_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.en && ctrl.mstr && ctrl.ss_ign && !wr_ctrl) |=> ctrl.mstr);

  assert_w1c_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && w1c_done && !byte_done) |=> !done_q);

  assert_irq_mask_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.ie |-> !irq);
endmodule

bind spi_dual_role spi_dr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl(ctrl_q), .ss_s(ss_s),
  .sclk_o(sclk_o), .sclk_oe(sclk_oe), .mosi_oe(mosi_oe), .miso_oe(miso_oe),
  .irq(irq), .busy_q(busy_q), .done_q(done_q), .col_q(col_q),
  .byte_done(byte_done), .col_evt(col_evt), .wr_ctrl(wr_ctrl),
  .wr_stat(wr_stat), .w1c_done(reg_wdata[7])
);

// File: tb/sim_spi_dual_role.sv
module sim_spi_dual_role;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       ss_i = 1'b1, sclk_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0;
  logic       sclk_o, sclk_oe, mosi_o, mosi_oe, miso_o, miso_oe, irq;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  spi_dual_role u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ss_i(ss_i),
    .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mk(input logic en, ig, ms, po, ph, ie, input logic [1:0] rt);
    return {en, ig, ms, po, ph, ie, rt};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  // ---- scoreboard: bench acts as slave for master transfers ----
  logic [7:0] exp_q[$];
  logic       mon_on = 1'b0;
  logic       b_cpol = 1'b0, b_cpha = 1'b0;
  int         exp_half = 2;
  logic [7:0] slv_tx = 8'h00, sreg, mon_rx;
  logic       sck_d;
  int         gap, edges_seen, bitn, k;

  always @(negedge clk) begin
    if (!mon_on) begin
      sck_d = b_cpol; gap = 0; edges_seen = 0; bitn = 0;
      sreg = slv_tx; miso_i = slv_tx[7];
    end else begin
      gap = gap + 1;
      if (sclk_o !== sck_d) begin
        if (edges_seen > 0) chk("R5 half period", gap, exp_half);
        gap = 0;
        edges_seen = edges_seen + 1;
        k = edges_seen;
        if ((!b_cpha && (k % 2 == 1)) || (b_cpha && (k % 2 == 0))) begin
          mon_rx = {mon_rx[6:0], mosi_o};
          bitn = bitn + 1;
          if (bitn == 8) begin
            bitn = 0;
            if (exp_q.size() == 0) chk("R4 unexpected byte", 1, 0);
            else chk("R4 mosi byte", mon_rx, exp_q.pop_front());
          end
        end else if (k < 16 && (!b_cpha || k > 1)) begin
          sreg = sreg << 1;
          miso_i = sreg[7];
        end
        sck_d = sclk_o;
      end
    end
  end

  task automatic master_xfer(input logic [7:0] tx, srx, input logic ig, po, ph, ie,
                             input logic [1:0] rt);
    logic [7:0] s;
    int t;
    b_cpol = po; b_cpha = ph; exp_half = 2 << rt; slv_tx = srx;
    wr(spi_dr_pkg::A_CTRL, mk(1, ig, 1, po, ph, ie, rt));
    @(negedge clk); #1;
    chk("R2 idle sclk level", sclk_o, po);
    chk("R2 master pin dirs", {sclk_oe, mosi_oe, miso_oe}, 3'b110);
    @(negedge clk); mon_on = 1'b1;
    exp_q.push_back(tx);
    wr(spi_dr_pkg::A_DATA, tx);
    t = 0;
    do begin rd(spi_dr_pkg::A_STAT, s); t++; end while (!s[7] && t < 2000);
    chk("R6 done flag", s[7], 1);
    chk("R6 edge count", edges_seen, 16);
    chk("R6 sclk back idle", sclk_o, po);
    chk("R12 irq with done", irq, ie);
    mon_on = 1'b0;
    rd(spi_dr_pkg::A_DATA, s);
    chk("R4 received byte", s, srx);
    chk("R4 scoreboard drained", exp_q.size(), 0);
    wr(spi_dr_pkg::A_STAT, 8'h80);
    rd(spi_dr_pkg::A_STAT, s);
    chk("R11 done cleared", s[7], 0);
    chk("R12 irq low after clear", irq, 0);
  endtask

  // ---- bench acts as master for slave transfers ----
  task automatic slv_byte(input logic [7:0] mo, input logic po, ph, output logic [7:0] mi);
    mi = 8'h00;
    for (int i = 0; i < 8; i++) begin
      if (!ph) begin
        mosi_i = mo[7-i];
        repeat (8) @(negedge clk);
        mi = {mi[6:0], miso_o};
        sclk_i = ~po;
        repeat (8) @(negedge clk);
        sclk_i = po;
      end else begin
        sclk_i = ~po;
        mosi_i = mo[7-i];
        repeat (8) @(negedge clk);
        mi = {mi[6:0], miso_o};
        sclk_i = po;
        repeat (8) @(negedge clk);
      end
    end
    repeat (8) @(negedge clk);
  endtask

  initial begin
    logic [7:0] s, mi;
    bit saw;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 reset pins free", {sclk_oe, mosi_oe, miso_oe}, 0);
    chk("R1 reset irq", irq, 0);
    rd(spi_dr_pkg::A_CTRL, s); chk("R1 reset ctrl", s, 0);
    rd(spi_dr_pkg::A_STAT, s); chk("R1 reset stat", s, 0);
    rd(spi_dr_pkg::A_DATA, s); chk("R1 reset data", s, 0);

    // R4 R5 R6: all four modes, all four dividers
    master_xfer(8'hA5, 8'h3C, 0, 0, 0, 1, 2'd0);
    master_xfer(8'h1E, 8'hC7, 0, 0, 1, 0, 2'd1);
    master_xfer(8'h80, 8'h01, 0, 1, 0, 1, 2'd2);
    master_xfer(8'h6D, 8'hF2, 0, 1, 1, 0, 2'd3);

    // R11: clear lands in the completion cycle
    wr(spi_dr_pkg::A_CTRL, mk(1, 0, 1, 0, 0, 0, 2'd0));
    @(negedge clk); reg_addr = spi_dr_pkg::A_DATA; reg_wdata = 8'h96; reg_wr = 1'b1;
    @(posedge clk);
    repeat (31) @(posedge clk);
    @(negedge clk); reg_addr = spi_dr_pkg::A_STAT; reg_wdata = 8'h80;
    @(negedge clk); reg_wr = 1'b0; #1;
    chk("R11 set wins over same-cycle clear", reg_rdata[7], 1);
    wr(spi_dr_pkg::A_STAT, 8'h80);
    rd(spi_dr_pkg::A_STAT, s); chk("R11 later clear", s[7], 0);

    // R10: select ignored, SS low keeps master
    ss_i = 1'b0;
    master_xfer(8'h5B, 8'hA2, 1, 0, 1, 0, 2'd0);
    rd(spi_dr_pkg::A_CTRL, s); chk("R10 master bit kept", s[5], 1);
    ss_i = 1'b1;
    repeat (4) @(negedge clk);

    // R9: mode fault
    wr(spi_dr_pkg::A_CTRL, mk(1, 0, 1, 0, 0, 1, 2'd0));
    repeat (4) @(negedge clk);
    ss_i = 1'b0; saw = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); #1; if (irq) saw = 1; end
    chk("R9 fault irq pulse", saw, 1);
    chk("R9 irq pulse ends", irq, 0);
    rd(spi_dr_pkg::A_CTRL, s); chk("R9 master bit cleared", s[5], 0);
    chk("R3 fallen master is selected slave", {sclk_oe, mosi_oe, miso_oe}, 3'b001);
    ss_i = 1'b1;

    // R3 R7 R8: slave, phase 0
    wr(spi_dr_pkg::A_CTRL, mk(1, 0, 0, 0, 0, 0, 2'd0));
    sclk_i = 1'b0;
    repeat (4) @(negedge clk); #1;
    chk("R3 unselected slave pins", {sclk_oe, mosi_oe, miso_oe}, 3'b000);
    wr(spi_dr_pkg::A_DATA, 8'hA5);
    ss_i = 1'b0;
    repeat (4) @(negedge clk); #1;
    chk("R3 selected slave drives miso", miso_oe, 1);
    wr(spi_dr_pkg::A_DATA, 8'h3C);
    rd(spi_dr_pkg::A_STAT, s); chk("R8 collision flag", s[6], 1);
    slv_byte(8'h5A, 0, 0, mi);
    chk("R8 discarded write, old byte sent", mi, 8'hA5);
    rd(spi_dr_pkg::A_STAT, s); chk("R7 slave done flag", s[7], 1);
    rd(spi_dr_pkg::A_DATA, s); chk("R7 slave received", s, 8'h5A);
    ss_i = 1'b1;
    wr(spi_dr_pkg::A_STAT, 8'hC0);
    rd(spi_dr_pkg::A_STAT, s); chk("R11 both flags cleared", s, 0);

    // R13: slave phase 1, SS held low across two bytes
    wr(spi_dr_pkg::A_CTRL, mk(1, 0, 0, 1, 1, 0, 2'd0));
    sclk_i = 1'b1;
    repeat (4) @(negedge clk);
    wr(spi_dr_pkg::A_DATA, 8'h81);
    ss_i = 1'b0;
    repeat (4) @(negedge clk);
    slv_byte(8'hC3, 1, 1, mi);
    chk("R13 first byte out", mi, 8'h81);
    rd(spi_dr_pkg::A_DATA, s); chk("R13 first byte in", s, 8'hC3);
    wr(spi_dr_pkg::A_STAT, 8'h80);
    slv_byte(8'h24, 1, 1, mi);
    rd(spi_dr_pkg::A_STAT, s); chk("R13 second done", s[7], 1);
    rd(spi_dr_pkg::A_DATA, s); chk("R13 second byte in", s, 8'h24);
    ss_i = 1'b1;

    // R1: disable frees pins
    wr(spi_dr_pkg::A_CTRL, 8'h00);
    @(negedge clk); #1;
    chk("R1 disabled pins free", {sclk_oe, mosi_oe, miso_oe}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule